// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switcher

This block picks the system clock from three candidate sources: a primary oscillator, a low-frequency secondary oscillator and an internal oscillator block. The internal block is a base clock followed by a postscaler, and the postscaler's rate is chosen by a 3-bit frequency code. Software writes a 2-bit source code at any time. The block takes up that code only when a power-mode entry strobe arrives, so the switch happens at a point that software controls.

Each source has its own gate lane. A lane drops its gate only while its clock is low. A lane raises its gate only after every other lane has been seen idle, and only after it has held its own clock low for a counted pause. The merged output therefore never carries a runt pulse and never mixes two sources. Control runs in the always-running internal base clock domain. Three mutually exclusive status flags report which source drives the output. A busy output covers the whole hand-over.

Top module: `clksw_top`

## Requirements
- R1: The source code is decoded as 00 = primary, 01 = secondary, 10 or 11 = internal block. After a completed switch, sys_clk runs at the period of the selected source.
- R2: A write to the source code changes nothing by itself. The output source changes only at a later accepted mode-entry strobe, and with no strobe the active source stays fixed.
- R3: Reset clears the source code to primary. While reset is held, busy and all flags are 0. After reset the primary source drives sys_clk, and a strobe after reset causes no switch even if the code was written before the reset.
- R4: A strobe that finds the secondary code selected while sec_en is 0 is ignored. Busy stays 0 and the current source stays in use.
- R5: During a switch, sys_clk stays low for at least PAUSE periods of the incoming clock. No high or low pulse is shorter than the shorter half-period of the two clocks involved. At most one lane gate is ever open.
- R6: The flags are stat_pri (primary gated and pri_ready), stat_sec (secondary gated) and stat_int (internal gated, int_stable, code not 0). At most one flag is set at any time.
- R7: No flag is set while the internal block drives at frequency code 0, or while int_stable is 0.
- R8: While the internal block drives, a change of ifreq takes effect within a few base cycles with no strobe. The codes select: 7 = base direct, 6 = /2, 5 = /4, 4 = /8, 3 = /16, 2 = /32, 1 = /64, 0 = /256 (the low-frequency rate).
- R9: Busy rises one control cycle after an accepted strobe that changes the source. It falls once the new lane is seen open. Strobes that arrive while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pri | input | 1 | Primary oscillator clock |
| clk_sec | input | 1 | Secondary low-frequency oscillator clock |
| clk_int | input | 1 | Internal block base clock; also clocks the control logic |
| sel_wr | input | 1 | Write strobe for the source code (clk_int domain) |
| sel_wdata | input | 2 | Source code written on sel_wr |
| ifreq | input | 3 | Internal postscaler frequency code |
| mode_strobe | input | 1 | Power-mode entry strobe that commits the source code |
| sec_en | input | 1 | Secondary oscillator enable |
| pri_ready | input | 1 | Primary oscillator started and running |
| int_stable | input | 1 | Internal block frequency stable |
| sys_clk | output | 1 | Glitch-free system clock |
| busy | output | 1 | Source switch in progress |
| stat_pri | output | 1 | Primary drives the clock |
| stat_int | output | 1 | Internal block drives the clock and is stable |
| stat_sec | output | 1 | Secondary drives the clock |

## Verification
The bench builds the block with its defaults, PAUSE = 8 and DIV_W = 8. The /256 tap then yields the low-frequency rate, and every frequency code can be measured in a short run. It uses three unrelated clock periods (10, 60 and 12 ns), so each switch crosses true asynchronous domains. With these clocks the runt-pulse bound is 5 ns and the held-low gap can be measured against eight periods of each incoming clock. Switches in the directions primary to internal, internal to secondary and secondary to primary are covered. The bench also covers a strobe during busy, a blocked secondary selection and a reset in the middle of a run.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  // Codes 10 and 11 both select the internal block.
  function automatic logic [1:0] sel_to_idx(input logic [1:0] code);
    return code[1] ? 2'(SRC_INT) : {1'b0, code[0]};
  endfunction
endpackage

// File: rtl/clksw_postscale.sv
`timescale 1ns/1ps
module clksw_postscale #(
  parameter int DIV_W = 8
) (
  input  logic       clk_base,
  input  logic       rst_n,
  input  logic [2:0] ifreq,
  output logic       clk_out
);
  localparam int TW = $clog2(DIV_W);

  logic [1:0]       rs_q;
  logic             prst_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [TW-1:0]    tap_idx;
  logic             tap_q, tap_n;

  always_ff @(posedge clk_base or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign prst_n = rs_q[1];

  // Code 0 takes the top bit; codes 1..6 walk down from bit 5 to bit 0.
  always_comb begin
    div_n   = div_q + 1'b1;
    tap_idx = (ifreq == 3'd0) ? TW'(DIV_W - 1) : TW'(3'd6 - ifreq);
    tap_n   = div_n[tap_idx];
  end

  always_ff @(posedge clk_base or negedge prst_n)
    if (!prst_n) begin
      div_q <= '0;
      tap_q <= 1'b0;
    end else begin
      div_q <= div_n;
      tap_q <= tap_n;
    end

  assign clk_out = (ifreq == 3'd7) ? clk_base : tap_q;
endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
module clksw_lane #(
  parameter int PAUSE = 8
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic want,
  input  logic others_on,
  output logic gate_on,
  output logic gclk
);
  localparam int            CW      = $clog2(PAUSE + 1);
  localparam logic [CW-1:0] PAUSE_C = CW'(PAUSE);

  logic [1:0]    rs_q;
  logic          lrst_n;
  logic [1:0]    s1_q, s2_q;
  logic          want_s, idle_s;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          gate_q, gate_n, ready_on;

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign lrst_n = rs_q[1];

  // Two-flop synchronizer for the request and the idle status of the other lanes.
  always_ff @(posedge clk_src or negedge lrst_n)
    if (!lrst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= {want, ~others_on};
      s2_q <= s1_q;
    end
  assign want_s = s2_q[1];
  assign idle_s = s2_q[0];

  always_comb begin
    cnt_n = cnt_q;
    if (!want_s || gate_q)                 cnt_n = '0;
    else if (idle_s && (cnt_q != PAUSE_C)) cnt_n = cnt_q + 1'b1;
    ready_on = want_s & idle_s & (cnt_q == PAUSE_C);
    gate_n   = want_s & (gate_q | ready_on);
  end

  always_ff @(posedge clk_src or negedge lrst_n)
    if (!lrst_n) cnt_q <= '0;
    else         cnt_q <= cnt_n;

  // The gate moves only on a falling edge, so it changes while clk_src is low.
  always_ff @(negedge clk_src or negedge lrst_n)
    if (!lrst_n) gate_q <= 1'b0;
    else         gate_q <= gate_n;

  assign gate_on = gate_q;
  assign gclk    = clk_src & gate_q;

  a_r5_pause_before_open: assert property (@(posedge clk_src) disable iff (!lrst_n)
    (gate_q && !$past(gate_q)) |-> (cnt_q == PAUSE_C));
endmodule

// File: rtl/clksw_ctl.sv
`timescale 1ns/1ps
module clksw_ctl
  import clksw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_wr,
  input  logic [1:0]      sel_wdata,
  input  logic            mode_strobe,
  input  logic            sec_en,
  input  logic [2:0]      ifreq,
  input  logic            pri_ready,
  input  logic            int_stable,
  input  logic [NSRC-1:0] gate_async,
  output logic [NSRC-1:0] want,
  output logic            busy,
  output logic [NSRC-1:0] flags
);
  logic [1:0]      rs_q;
  logic            crst_n;
  logic [NSRC+1:0] y1_q, y2_q;
  logic [NSRC-1:0] gate_s;
  logic            pri_rdy_s, int_stab_s;
  logic [1:0]      sel_q, sel_n, act_q, act_n, sel_idx, tgt;
  logic            busy_q, busy_n, accept;
  logic [NSRC-1:0] flags_q, flags_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  assign crst_n = rs_q[1];

  always_ff @(posedge clk or negedge crst_n)
    if (!crst_n) begin
      y1_q <= '0;
      y2_q <= '0;
    end else begin
      y1_q <= {pri_ready, int_stable, gate_async};
      y2_q <= y1_q;
    end
  assign gate_s     = y2_q[NSRC-1:0];
  assign int_stab_s = y2_q[NSRC];
  assign pri_rdy_s  = y2_q[NSRC+1];

  assign want = NSRC'(1) << act_q;

  always_comb begin
    sel_idx = sel_to_idx(sel_q);
    tgt     = ((sel_idx == SRC_SEC) && !sec_en) ? act_q : sel_idx;
    accept  = mode_strobe & ~busy_q;
    sel_n   = sel_wr ? sel_wdata : sel_q;
    act_n   = accept ? tgt : act_q;
    busy_n  = busy_q ? (gate_s != want) : (accept && (tgt != act_q));
    flags_n          = '0;
    flags_n[SRC_PRI] = gate_s[SRC_PRI] & pri_rdy_s;
    flags_n[SRC_SEC] = gate_s[SRC_SEC];
    flags_n[SRC_INT] = gate_s[SRC_INT] & int_stab_s & (ifreq != 3'd0);
  end

  always_ff @(posedge clk or negedge crst_n)
    if (!crst_n) begin
      sel_q   <= 2'(SRC_PRI);
      act_q   <= 2'(SRC_PRI);
      busy_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      sel_q   <= sel_n;
      act_q   <= act_n;
      busy_q  <= busy_n;
      flags_q <= flags_n;
    end

  assign busy  = busy_q;
  assign flags = flags_q;

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!crst_n)
    $onehot0(flags_q));
  a_r2_no_strobe_holds: assert property (@(posedge clk) disable iff (!crst_n)
    !mode_strobe |=> $stable(act_q));
  a_r9_busy_ignores_strobe: assert property (@(posedge clk) disable iff (!crst_n)
    busy_q |=> $stable(act_q));
  a_r4_sec_blocked: assert property (@(posedge clk) disable iff (!crst_n)
    (mode_strobe && (sel_q == 2'(SRC_SEC)) && !sec_en) |=> $stable(act_q));
  a_r7_lf_no_int_flag: assert property (@(posedge clk) disable iff (!crst_n)
    (ifreq == 3'd0) |=> !flags_q[SRC_INT] || ($past(ifreq) != 3'd0));
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int PAUSE = 8,
  parameter int DIV_W = 8
) (
  input  logic       rst_n,
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       clk_int,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic [2:0] ifreq,
  input  logic       mode_strobe,
  input  logic       sec_en,
  input  logic       pri_ready,
  input  logic       int_stable,
  output logic       sys_clk,
  output logic       busy,
  output logic       stat_pri,
  output logic       stat_int,
  output logic       stat_sec
);
  logic            int_clk;
  logic [NSRC-1:0] lane_clk, gate_on, gclk, others_on, want, flags;

  clksw_postscale #(.DIV_W(DIV_W)) u_post (
    .clk_base (clk_int),
    .rst_n    (rst_n),
    .ifreq    (ifreq),
    .clk_out  (int_clk)
  );

  assign lane_clk[SRC_PRI] = clk_pri;
  assign lane_clk[SRC_SEC] = clk_sec;
  assign lane_clk[SRC_INT] = int_clk;

  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    assign others_on[i] = |(gate_on & ~(NSRC'(1) << i));
    clksw_lane #(.PAUSE(PAUSE)) u_lane (
      .clk_src   (lane_clk[i]),
      .rst_n     (rst_n),
      .want      (want[i]),
      .others_on (others_on[i]),
      .gate_on   (gate_on[i]),
      .gclk      (gclk[i])
    );
  end

  clksw_ctl u_ctl (
    .clk         (clk_int),
    .rst_n       (rst_n),
    .sel_wr      (sel_wr),
    .sel_wdata   (sel_wdata),
    .mode_strobe (mode_strobe),
    .sec_en      (sec_en),
    .ifreq       (ifreq),
    .pri_ready   (pri_ready),
    .int_stable  (int_stable),
    .gate_async  (gate_on),
    .want        (want),
    .busy        (busy),
    .flags       (flags)
  );

  assign sys_clk  = |gclk;
  assign stat_pri = flags[SRC_PRI];
  assign stat_sec = flags[SRC_SEC];
  assign stat_int = flags[SRC_INT];

  a_r5_single_gate: assert property (@(posedge clk_int) disable iff (!rst_n)
    $onehot0(gate_on));
endmodule

// File: tb/sim_clksw_top.sv
`timescale 1ns/1ps
module sim_clksw_top;
  localparam int CLK_PERIOD = 10;   // primary
  localparam int SEC_PERIOD = 60;
  localparam int INT_PERIOD = 12;
  localparam int WATCHDOG   = 2000000;

  logic rst_n = 1'b0, clk_pri = 1'b0, clk_sec = 1'b0, clk_int = 1'b0;
  logic sel_wr = 1'b0, mode_strobe = 1'b0, sec_en = 1'b1;
  logic pri_ready = 1'b1, int_stable = 1'b1;
  logic [1:0] sel_wdata = 2'd0;
  logic [2:0] ifreq = 3'd7;
  logic sys_clk, busy, stat_pri, stat_int, stat_sec;
  logic [2:0] act_flags;

  always #(CLK_PERIOD/2) clk_pri = ~clk_pri;
  always #(SEC_PERIOD/2) clk_sec = ~clk_sec;
  always #(INT_PERIOD/2) clk_int = ~clk_int;

  clksw_top u0 (
    .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec), .clk_int(clk_int),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .ifreq(ifreq),
    .mode_strobe(mode_strobe), .sec_en(sec_en), .pri_ready(pri_ready),
    .int_stable(int_stable), .sys_clk(sys_clk), .busy(busy),
    .stat_pri(stat_pri), .stat_int(stat_int), .stat_sec(stat_sec)
  );
  assign act_flags = {stat_int, stat_sec, stat_pri};

  int n_checks = 0, n_fail = 0;
  int n_pushed = 0, n_done = 0;
  int runt_cnt = 0;
  bit glitch_en = 1'b0;
  real last_t = 0.0, max_low = 0.0;

  typedef struct {
    string      tag;
    logic [2:0] flags;
    int         period;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Runt-pulse and gap monitor on sys_clk (R5)
  always @(sys_clk) begin
    real w;
    w = $realtime - last_t;
    if (glitch_en && last_t > 0.0 && w < 4.5) runt_cnt++;
    if (sys_clk && w > max_low) max_low = w;
    last_t = $realtime;
  end

  // Scoreboard monitor: pops the expected item, waits for settle, compares.
  initial begin
    exp_t it;
    real t0, per;
    forever begin
      wait (n_pushed > n_done);
      it = exp_q.pop_front();
      #(20*INT_PERIOD);
      wait (busy == 1'b0);
      #(20*INT_PERIOD);
      repeat (3) @(posedge sys_clk);
      t0 = $realtime;
      @(posedge sys_clk);
      per = $realtime - t0;
      check(act_flags == it.flags, {it.tag, " flags"}, int'(act_flags), int'(it.flags));
      check(per > it.period - 0.5 && per < it.period + 0.5, {it.tag, " period"},
            int'(per), it.period);
      n_done++;
    end
  end

  task automatic push_exp(input string tag, input logic [2:0] f, input int p);
    exp_t it;
    it.tag = tag; it.flags = f; it.period = p;
    exp_q.push_back(it);
    n_pushed++;
  endtask

  task automatic drain();
    wait (n_done == n_pushed);
  endtask

  task automatic wr_sel(input logic [1:0] v);
    @(negedge clk_int); sel_wr = 1'b1; sel_wdata = v;
    @(negedge clk_int); sel_wr = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk_int); mode_strobe = 1'b1;
    @(negedge clk_int); mode_strobe = 1'b0;
  endtask

  task automatic finish_run();
    check(runt_cnt == 0, "R5 runt pulses", runt_cnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(WATCHDOG);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #(10*CLK_PERIOD);
    check(act_flags == 3'b000, "R3 reset flags", int'(act_flags), 0);
    check(busy == 1'b0, "R3 reset busy", int'(busy), 0);
    @(negedge clk_int); rst_n = 1'b1;
    glitch_en = 1'b1;
    push_exp("R1 primary after reset", 3'b001, CLK_PERIOD);
    drain();

    // R2: write internal code, no strobe -> primary stays
    wr_sel(2'b10);
    repeat (50) @(negedge clk_int);
    push_exp("R2 write pending", 3'b001, CLK_PERIOD);
    drain();

    // R1/R9/R5: commit to internal block
    max_low = 0.0;
    strobe();
    @(negedge clk_int);
    check(busy == 1'b1, "R9 busy after strobe", int'(busy), 1);
    push_exp("R1 internal active", 3'b100, INT_PERIOD);
    drain();
    check(max_low >= 8.0*INT_PERIOD, "R5 gap to internal", int'(max_low), 8*INT_PERIOD);

    // R8/R7: frequency codes take effect without a strobe
    glitch_en = 1'b0;
    @(negedge clk_int); ifreq = 3'd6;
    push_exp("R8 code 6 /2", 3'b100, 2*INT_PERIOD);
    drain();
    @(negedge clk_int); ifreq = 3'd1;
    push_exp("R8 code 1 /64", 3'b100, 64*INT_PERIOD);
    drain();
    @(negedge clk_int); ifreq = 3'd0;
    push_exp("R7 low-frequency rate", 3'b000, 256*INT_PERIOD);
    drain();
    @(negedge clk_int); ifreq = 3'd7;
    push_exp("R8 code 7 direct", 3'b100, INT_PERIOD);
    drain();
    glitch_en = 1'b1;

    // R7: unstable internal block reports no flag
    @(negedge clk_int); int_stable = 1'b0;
    push_exp("R7 not stable", 3'b000, INT_PERIOD);
    drain();
    @(negedge clk_int); int_stable = 1'b1;

    // R9: switch to secondary, second strobe while busy is ignored
    wr_sel(2'b01);
    max_low = 0.0;
    strobe();
    wr_sel(2'b00);
    check(busy == 1'b1, "R9 busy during switch", int'(busy), 1);
    strobe();
    push_exp("R9 secondary kept", 3'b010, SEC_PERIOD);
    drain();
    check(max_low >= 8.0*SEC_PERIOD, "R5 gap to secondary", int'(max_low), 8*SEC_PERIOD);
    repeat (100) @(negedge clk_int);
    push_exp("R9 no late switch", 3'b010, SEC_PERIOD);
    drain();

    // R2: pending primary code applies at next strobe
    max_low = 0.0;
    strobe();
    push_exp("R2 primary on strobe", 3'b001, CLK_PERIOD);
    drain();
    check(max_low >= 8.0*CLK_PERIOD, "R5 gap to primary", int'(max_low), 8*CLK_PERIOD);

    // R4: secondary blocked when its enable is clear
    @(negedge clk_int); sec_en = 1'b0;
    wr_sel(2'b01);
    strobe();
    repeat (2) @(negedge clk_int);
    check(busy == 1'b0, "R4 no switch busy", int'(busy), 0);
    push_exp("R4 primary kept", 3'b001, CLK_PERIOD);
    drain();

    // R3: reset clears a written code
    wr_sel(2'b10);
    glitch_en = 1'b0;
    @(negedge clk_int); rst_n = 1'b0;
    repeat (5) @(negedge clk_int);
    check(act_flags == 3'b000, "R3 flags in reset", int'(act_flags), 0);
    rst_n = 1'b1;
    repeat (60) @(negedge clk_int);
    glitch_en = 1'b1;
    strobe();
    repeat (2) @(negedge clk_int);
    check(busy == 1'b0, "R3 code cleared busy", int'(busy), 0);
    push_exp("R3 code cleared primary", 3'b001, CLK_PERIOD);
    drain();

    finish_run();
  end
endmodule